// File: doc/BRIEF.md
# Odd/Even Pixel Merger and Colour Row Aligner

This block sits behind the digitisers of a three-colour linear image sensor whose colour rows are read out in parallel. Each colour arrives as an odd-pixel sample and an even-pixel sample in the same beat. The block puts every pair back into natural pixel order, so the odd pixel comes out first and the even pixel second.

The three photocell rows see the page at different moments, because neighbouring rows sit `LINE_GAP` scan lines apart. The block therefore delays the first-scanned colour by two gaps and the middle colour by one gap, using on-chip line stores. The last-scanned colour passes straight through. One RGB pixel leaves per output beat, with start-of-line and end-of-line marks and a valid/ready handshake.

At the head of each line there is a group of shielded pixels. These are passed on a side port for black-level estimation and never reach the pixel stream. Pixels that follow the valid region are dropped.

A line framing state machine classifies every input pair. Its states are:
- FR_IDLE: waiting for the first line mark after reset.
- FR_BLACK: shielded pairs.
- FR_ACTIVE: valid pairs.
- FR_TAIL: trailing pairs, which are discarded.

Its transitions are:
- A line-start beat enters FR_BLACK from any state. It enters FR_ACTIVE directly if there is only one shielded pair.
- The last shielded pair moves FR_BLACK to FR_ACTIVE.
- The last valid pair moves FR_ACTIVE to FR_TAIL.

An output state machine drives the pixel stream. Its states are:
- HO_EMPTY: nothing held.
- HO_ODD: presenting the odd pixel of the held pair.
- HO_EVEN: presenting the even pixel of the held pair.

Its transitions are:
- A pair loads into HO_EMPTY, which moves to HO_ODD.
- Ready moves HO_ODD to HO_EVEN.
- In HO_EVEN with ready, a new pair moves to HO_ODD; with no new pair it moves to HO_EMPTY.

Top module: `rgb_row_aligner`

## Requirements
- R1: Each emitted valid pair appears as two output beats: the odd pixel (pixel 2k+1) first, then the even pixel (pixel 2k+2). Pixels are packed red in the top `DW` bits, green in the middle and blue in the low bits, on inputs and outputs alike.
- R2: A line begins at a beat with `in_valid` and `in_sol` high. The pair in that beat and the following `OB_PIX/2-1` pairs are shielded. The next `VALID_PIX/2` pairs are valid, and any later pairs are discarded. Pairs seen before the first line start are ignored. Only valid pixels reach `out_pix`.
- R3: One cycle after each shielded pair is accepted, `ob_valid` is high and `ob_odd`/`ob_even` carry that pair.
- R4: With `scan_rev`=0, pixel j of output line L takes red from input line L-2·`LINE_GAP`, green from line L-`LINE_GAP`, and blue from line L.
- R5: With `scan_rev`=1, red comes from line L, green from line L-`LINE_GAP`, and blue from line L-2·`LINE_GAP`.
- R6: After reset, `out_valid`, `ob_valid` and `overflow` are low. No pixel is emitted until 2·`LINE_GAP` complete lines have been received.
- R7: `out_sol` is high only with the first pixel of a line, and `out_eol` only with the last.
- R8: While `out_valid` is high and `out_ready` is low, `out_pix`, `out_sol` and `out_eol` keep their values.
- R9: A valid pair that arrives when the output stage cannot take it is lost from the stream. When this happens, `overflow` rises and stays high until reset. The line stores are still updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_rev | input | 1 | Reverses which colour gets the longest delay; held static while running |
| in_valid | input | 1 | An input pair is present |
| in_sol | input | 1 | This pair is the first of a line |
| in_odd | input | 3*DW | Odd-pixel samples {R,G,B} |
| in_even | input | 3*DW | Even-pixel samples {R,G,B} |
| out_ready | input | 1 | Downstream accepts a pixel |
| out_valid | output | 1 | A pixel is offered |
| out_pix | output | 3*DW | Aligned pixel {R,G,B} |
| out_sol | output | 1 | First pixel of the line |
| out_eol | output | 1 | Last pixel of the line |
| ob_valid | output | 1 | A shielded pair is on the side port |
| ob_odd | output | 3*DW | Shielded odd samples {R,G,B} |
| ob_even | output | 3*DW | Shielded even samples {R,G,B} |
| overflow | output | 1 | Sticky flag: a valid pair was lost |

## Verification
Several properties are checked on every cycle:
- output stability under back-pressure;
- stickiness of the overflow flag;
- the rule that an end-of-line transfer is followed only by a start-of-line pixel or no pixel at all;
- gating of the output until the warm-up count completes;
- the shielded side port answering each line start;
- wrapping of the line-store slot counters.

Only the bench scenarios can show the data itself: the odd-then-even order, which input line each colour comes from in both scan directions, the exact pixel count per line, and that dropped pairs still refresh the line stores.

// File: rtl/cla_pkg.sv
package cla_pkg;
    typedef enum logic [1:0] {FR_IDLE, FR_BLACK, FR_ACTIVE, FR_TAIL} fr_state_t;
    typedef enum logic [1:0] {HO_EMPTY, HO_ODD, HO_EVEN} ho_state_t;
    typedef enum logic [1:0] {PC_NONE, PC_BLACK, PC_VALID} pair_cls_t;
endpackage

// File: rtl/cla_framer.sv
module cla_framer
    import cla_pkg::*;
#(
    parameter int OB_PAIRS = 2,
    parameter int V_PAIRS  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_sol,
    output pair_cls_t                   cls,
    output logic [$clog2(V_PAIRS)-1:0]  idx,
    output logic                        first,
    output logic                        last
);
    localparam int MAXP = (OB_PAIRS > V_PAIRS) ? OB_PAIRS : V_PAIRS;
    localparam int CW   = $clog2(MAXP + 1);
    localparam int IW   = $clog2(V_PAIRS);

    fr_state_t      state, nstate;
    logic [CW-1:0]  cnt, ncnt, cur;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FR_IDLE;
            cnt   <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
        end
    end

    // classification and next state
    always_comb begin
        cls    = PC_NONE;
        cur    = cnt;
        nstate = state;
        ncnt   = cnt;
        if (in_valid) begin
            if (in_sol) begin
                cls = PC_BLACK;
                cur = '0;
                if (OB_PAIRS == 1) begin
                    nstate = FR_ACTIVE;
                    ncnt   = '0;
                end else begin
                    nstate = FR_BLACK;
                    ncnt   = CW'(1);
                end
            end else begin
                unique case (state)
                    FR_IDLE, FR_TAIL: begin
                        cls = PC_NONE;
                    end
                    FR_BLACK: begin
                        cls = PC_BLACK;
                        if (cnt == CW'(OB_PAIRS - 1)) begin
                            nstate = FR_ACTIVE;
                            ncnt   = '0;
                        end else begin
                            ncnt = cnt + CW'(1);
                        end
                    end
                    FR_ACTIVE: begin
                        cls = PC_VALID;
                        if (cnt == CW'(V_PAIRS - 1)) begin
                            nstate = FR_TAIL;
                            ncnt   = '0;
                        end else begin
                            ncnt = cnt + CW'(1);
                        end
                    end
                    default: nstate = FR_IDLE;
                endcase
            end
        end
    end

    assign idx   = cur[IW-1:0];
    assign first = (cls == PC_VALID) && (cur == '0);
    assign last  = (cls == PC_VALID) && (cur == CW'(V_PAIRS - 1));

    // R2: the valid-pair counter never leaves the valid region
    p_active_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_ACTIVE) |-> (cnt < CW'(V_PAIRS)));
endmodule

// File: rtl/cla_line_store.sv
module cla_line_store #(
    parameter int W     = 12,
    parameter int LINES = 8,
    parameter int PAIRS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic                       adv,
    input  logic [$clog2(PAIRS)-1:0]   idx,
    input  logic [2*W-1:0]             wdata,
    output logic [2*W-1:0]             rdata
);
    localparam int SW    = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int DEPTH = LINES * PAIRS;
    localparam int AW    = $clog2(DEPTH);

    logic [2*W-1:0] mem [DEPTH];
    logic [SW-1:0]  slot;
    logic [AW-1:0]  addr;

    assign addr  = AW'(int'(slot) * PAIRS + int'(idx));
    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          slot <= '0;
        else if (adv && slot == SW'(LINES-1)) slot <= '0;
        else if (adv)                         slot <= slot + SW'(1);
    end

    // R4: the ring of line slots wraps after LINES lines
    p_slot_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && slot == SW'(LINES-1)) |=> (slot == '0));
endmodule

// File: rtl/cla_pixel_hold.sv
module cla_pixel_hold
    import cla_pkg::*;
#(
    parameter int W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [3*W-1:0] odd_in,
    input  logic [3*W-1:0] even_in,
    input  logic           first_in,
    input  logic           last_in,
    input  logic           out_ready,
    output logic           out_valid,
    output logic [3*W-1:0] out_pix,
    output logic           out_sol,
    output logic           out_eol,
    output logic           overflow
);
    ho_state_t      state, nstate;
    logic [3*W-1:0] odd_q, even_q;
    logic           first_q, last_q;
    logic           take;

    assign take = load && ((state == HO_EMPTY) || (state == HO_EVEN && out_ready));

    always_comb begin
        nstate = state;
        unique case (state)
            HO_EMPTY: if (take)      nstate = HO_ODD;
            HO_ODD:   if (out_ready) nstate = HO_EVEN;
            HO_EVEN:  if (take)      nstate = HO_ODD;
                      else if (out_ready) nstate = HO_EMPTY;
            default:  nstate = HO_EMPTY;
        endcase
    end

    // state register and held pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= HO_EMPTY;
            odd_q    <= '0;
            even_q   <= '0;
            first_q  <= 1'b0;
            last_q   <= 1'b0;
            overflow <= 1'b0;
        end else begin
            state <= nstate;
            if (take) begin
                odd_q   <= odd_in;
                even_q  <= even_in;
                first_q <= first_in;
                last_q  <= last_in;
            end
            if (load && !take) overflow <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        out_valid = (state != HO_EMPTY);
        out_pix   = (state == HO_EVEN) ? even_q : odd_q;
        out_sol   = (state == HO_ODD)  && first_q;
        out_eol   = (state == HO_EVEN) && last_q;
    end

    // R8: offered pixel frozen under back-pressure
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)
                                       && $stable(out_sol) && $stable(out_eol)));
    // R9: overflow never clears on its own
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R7: after a line's last pixel leaves, only a line start may follow
    p_eol_then_sol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eol) |=> (!out_valid || out_sol));
endmodule

// File: rtl/rgb_row_aligner.sv
module rgb_row_aligner
    import cla_pkg::*;
#(
    parameter int DW        = 12,
    parameter int VALID_PIX = 16,
    parameter int OB_PIX    = 4,
    parameter int LINE_GAP  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scan_rev,
    input  logic            in_valid,
    input  logic            in_sol,
    input  logic [3*DW-1:0] in_odd,
    input  logic [3*DW-1:0] in_even,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [3*DW-1:0] out_pix,
    output logic            out_sol,
    output logic            out_eol,
    output logic            ob_valid,
    output logic [3*DW-1:0] ob_odd,
    output logic [3*DW-1:0] ob_even,
    output logic            overflow
);
    localparam int V_PAIRS  = VALID_PIX / 2;
    localparam int OB_PAIRS = OB_PIX / 2;
    localparam int DEEP     = 2 * LINE_GAP;
    localparam int WCW      = $clog2(DEEP + 1);
    localparam int IW       = $clog2(V_PAIRS);

    pair_cls_t      cls;
    logic [IW-1:0]  idx;
    logic           first, last, warm, store_we;
    logic [WCW-1:0] lines_seen;

    logic [DW-1:0] r_o, g_o, b_o, r_e, g_e, b_e;
    logic [2*DW-1:0] deep_wr, deep_rd, mid_rd, now_pair, r_pair, b_pair;
    logic [3*DW-1:0] odd_rgb, even_rgb;

    cla_framer #(.OB_PAIRS(OB_PAIRS), .V_PAIRS(V_PAIRS)) u_framer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .cls(cls), .idx(idx), .first(first), .last(last));

    assign {r_o, g_o, b_o} = in_odd;
    assign {r_e, g_e, b_e} = in_even;
    assign store_we = (cls == PC_VALID);

    // first-scanned colour goes through the deep store
    assign deep_wr  = scan_rev ? {b_o, b_e} : {r_o, r_e};
    assign now_pair = scan_rev ? {r_o, r_e} : {b_o, b_e};

    cla_line_store #(.W(DW), .LINES(DEEP), .PAIRS(V_PAIRS)) u_deep (
        .clk(clk), .rst_n(rst_n), .we(store_we), .adv(last), .idx(idx),
        .wdata(deep_wr), .rdata(deep_rd));

    cla_line_store #(.W(DW), .LINES(LINE_GAP), .PAIRS(V_PAIRS)) u_mid (
        .clk(clk), .rst_n(rst_n), .we(store_we), .adv(last), .idx(idx),
        .wdata({g_o, g_e}), .rdata(mid_rd));

    assign r_pair   = scan_rev ? now_pair : deep_rd;
    assign b_pair   = scan_rev ? deep_rd  : now_pair;
    assign odd_rgb  = {r_pair[2*DW-1:DW], mid_rd[2*DW-1:DW], b_pair[2*DW-1:DW]};
    assign even_rgb = {r_pair[DW-1:0],    mid_rd[DW-1:0],    b_pair[DW-1:0]};

    // warm-up: count complete lines until every store holds real data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     lines_seen <= '0;
        else if (last && lines_seen != WCW'(DEEP))      lines_seen <= lines_seen + WCW'(1);
    end
    assign warm = (lines_seen == WCW'(DEEP));

    cla_pixel_hold #(.W(DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(store_we && warm),
        .odd_in(odd_rgb), .even_in(even_rgb), .first_in(first), .last_in(last),
        .out_ready(out_ready), .out_valid(out_valid), .out_pix(out_pix),
        .out_sol(out_sol), .out_eol(out_eol), .overflow(overflow));

    // shielded side port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ob_valid <= 1'b0;
            ob_odd   <= '0;
            ob_even  <= '0;
        end else begin
            ob_valid <= (cls == PC_BLACK);
            if (cls == PC_BLACK) begin
                ob_odd  <= in_odd;
                ob_even <= in_even;
            end
        end
    end

    // R6: no pixel offered before the warm-up count completes
    p_warm_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> warm);
    // R3: a line start always yields a shielded beat next cycle
    p_ob_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |=> ob_valid);
endmodule

// File: tb/tb_rgb_row_aligner.sv
module tb_rgb_row_aligner;
    localparam int DW = 12, VP = 16, OBP = 4, GAP = 4;
    localparam int VPAIRS = VP / 2, OBPAIRS = OBP / 2, TAILP = 2;

    logic clk = 1'b0, rst_n = 1'b0, scan_rev = 1'b0;
    logic in_valid = 1'b0, in_sol = 1'b0, out_ready = 1'b1;
    logic [3*DW-1:0] in_odd = '0, in_even = '0;
    logic out_valid, out_sol, out_eol, ob_valid, overflow;
    logic [3*DW-1:0] out_pix, ob_odd, ob_even;

    int checks = 0, fails = 0, cap_n = 0, ob_n = 0, cur_line = 0;
    logic [3*DW-1:0] cap_pix [64];
    logic            cap_sol [64];
    logic            cap_eol [64];
    bit done = 1'b0;

    always #5 clk = ~clk;

    rgb_row_aligner #(.DW(DW), .VALID_PIX(VP), .OB_PIX(OBP), .LINE_GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .scan_rev(scan_rev), .in_valid(in_valid),
        .in_sol(in_sol), .in_odd(in_odd), .in_even(in_even), .out_ready(out_ready),
        .out_valid(out_valid), .out_pix(out_pix), .out_sol(out_sol), .out_eol(out_eol),
        .ob_valid(ob_valid), .ob_odd(ob_odd), .ob_even(ob_even), .overflow(overflow));

    function automatic logic [DW-1:0] pv(int c, int l, int code);
        logic [1:0] cc = c[1:0];
        logic [4:0] ll = l[4:0];
        logic [4:0] pp = code[4:0];
        return {cc, ll, pp};
    endfunction

    function automatic logic [3*DW-1:0] rgb(int lr, int lg, int lb, int code);
        return {pv(0, lr, code), pv(1, lg, code), pv(2, lb, code)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                cap_pix[cap_n % 64] = out_pix;
                cap_sol[cap_n % 64] = out_sol;
                cap_eol[cap_n % 64] = out_eol;
                cap_n++;
            end
            if (ob_valid) begin
                ob_n++;
                // R3: side port carries the current line's shielded samples
                chk(ob_odd[3*DW-3 -: 5] == cur_line[4:0] && ob_odd[3*DW-8 -: 5] >= 5'd16
                    && ob_odd[3*DW-8 -: 5] < 5'd20 && ob_even[3*DW-8 -: 5] == ob_odd[3*DW-8 -: 5] + 5'd1,
                    "R3", 64'(ob_odd), 64'(cur_line));
            end
        end
    end

    task automatic drive_pair(input bit sol, input int l, input int code);
        in_valid = 1'b1;
        in_sol   = sol;
        in_odd   = rgb(l, l, l, code);
        in_even  = rgb(l, l, l, code + 1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_sol   = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic send_line(input int l);
        cur_line = l;
        for (int k = 0; k < OBPAIRS + VPAIRS + TAILP; k++) begin
            if (k < OBPAIRS)               drive_pair(k == 0, l, 16 + 2*k);
            else if (k < OBPAIRS + VPAIRS) drive_pair(1'b0, l, 2*(k - OBPAIRS));
            else                           drive_pair(1'b0, l, 24 + 2*(k - OBPAIRS - VPAIRS));
        end
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input bit rev);
        rst_n = 1'b0;
        scan_rev = rev;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(!out_valid && !ob_valid && !overflow, "R6", 64'({out_valid, ob_valid, overflow}), 64'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    // check one aligned line: red/green/blue source lines given
    task automatic check_line(input int base, input int lr, input int lg, input int lb, input string req);
        chk(cap_n - base == VP, "R2", 64'(cap_n - base), 64'(VP));
        for (int j = 0; j < VP; j++) begin
            chk(cap_pix[(base + j) % 64] == rgb(lr, lg, lb, j), req,
                64'(cap_pix[(base + j) % 64]), 64'(rgb(lr, lg, lb, j)));
            // R1 order is implied by pixel code j; R7 marks
            chk(cap_sol[(base + j) % 64] == (j == 0) && cap_eol[(base + j) % 64] == (j == VP - 1),
                "R7", 64'({cap_sol[(base + j) % 64], cap_eol[(base + j) % 64]}), 64'(j));
        end
    endtask

    task automatic t_pre_sol();
        int b = cap_n, o = ob_n;
        for (int k = 0; k < 4; k++) drive_pair(1'b0, 30, 2*k);
        repeat (3) @(posedge clk); #1;
        chk(cap_n == b && ob_n == o, "R2", 64'(cap_n - b + ob_n - o), 64'd0);
    endtask

    task automatic t_warmup(input int nlines);
        int b = cap_n, o = ob_n;
        for (int l = 0; l < nlines; l++) send_line(l);
        chk(cap_n == b, "R6", 64'(cap_n - b), 64'd0);
        chk(ob_n - o == nlines * OBPAIRS, "R3", 64'(ob_n - o), 64'(nlines * OBPAIRS));
    endtask

    task automatic t_fwd_lines();
        for (int l = 2*GAP; l < 2*GAP + 3; l++) begin
            int b = cap_n;
            send_line(l);
            check_line(b, l - 2*GAP, l - GAP, l, "R4");
        end
        chk(!overflow, "R9", 64'(overflow), 64'd0);
    endtask

    task automatic t_stall();
        int b = cap_n;
        int l = 2*GAP + 3;
        out_ready = 1'b0;
        send_line(l);
        chk(out_valid && out_sol && out_pix == rgb(l - 2*GAP, l - GAP, l, 0), "R8",
            64'(out_pix), 64'(rgb(l - 2*GAP, l - GAP, l, 0)));
        chk(overflow, "R9", 64'(overflow), 64'd1);
        out_ready = 1'b1;
        repeat (4) @(posedge clk); #1;
        chk(cap_n - b == 2, "R9", 64'(cap_n - b), 64'd2);
        chk(cap_pix[(b + 1) % 64] == rgb(l - 2*GAP, l - GAP, l, 1), "R1",
            64'(cap_pix[(b + 1) % 64]), 64'(rgb(l - 2*GAP, l - GAP, l, 1)));
        // stores kept filling during the drop: next line still aligned
        b = cap_n;
        send_line(l + 1);
        check_line(b, l + 1 - 2*GAP, l + 1 - GAP, l + 1, "R9");
        chk(overflow, "R9", 64'(overflow), 64'd1);
    endtask

    task automatic t_reverse();
        int b;
        do_reset(1'b1);
        t_warmup(2*GAP);
        b = cap_n;
        send_line(2*GAP);
        check_line(b, 2*GAP, GAP, 0, "R5");
    endtask

    initial begin
        do_reset(1'b0);
        t_pre_sol();
        t_warmup(2*GAP);
        t_fwd_lines();
        t_stall();
        t_reverse();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule